// File: doc/BRIEF.md
# Protected-Source Watchdog Timer

This block is a down-counting watchdog that software must restart at regular intervals. A write of any value to the start register loads the counter with its full-scale value and sets it running. If software fails to restart it in time, the counter passes zero and the block raises a one-cycle interrupt request or reset request. In normal mode the counter advances on a prescaled system-clock enable, with a selectable ratio. The block is reached through a small byte-wide register bus with four addresses.

A protected mode locks the counter to an always-running oscillator enable. Changes to this mode go through an unlock bit in a protect register. Once selected, the oscillator source cannot be turned off again except by a system reset. In this mode the prescaler is bypassed and the counter keeps running through wait mode. Stop-mode requests are also refused, so a run-away program cannot silence the watchdog by halting the clocks.

Top module: `wdt_guard`

## Requirements
- R1: Any write to the start register (address 1) loads the counter with 2^CNT_W-1 and starts counting, whatever data is written. After reset the counter stays idle at full scale until the first such write.
- R2: In normal mode the counter decrements once every N asserted `sys_tick` cycles. N is 2^PRE_LO_LOG2 when control bit 7 is 0 and 2^PRE_HI_LOG2 when it is 1, so a full period is 2^CNT_W*N ticks.
- R3: A read of the control register (address 0) returns the prescaler select in bit 7, zeros in bits 6..5, and the five most significant counter bits in bits 4..0. Writes to bits 6..0 are ignored.
- R4: Bit 0 of the protect register (address 2) is read/write. While it is 0, writes to the mode register (address 3) leave the mode register unchanged.
- R5: With mode bit 0 set, an underflow pulses `wdt_rst` and leaves `wdt_irq` low. With mode bit 0 clear, an underflow pulses `wdt_irq` and leaves `wdt_rst` low.
- R6: With mode bit 1 set, the counter decrements once per asserted `osc_tick` without any prescaling. A full period is then exactly 2^CNT_W oscillator ticks, and `sys_tick` has no effect.
- R7: A permitted write to the mode register with bit 2 set pulses `stop_req` for one cycle after the write edge. No pulse is produced when mode bit 1 is already set or is being set by the same write.
- R8: In normal mode, `wait_mode` high freezes the counter. With mode bit 1 set, the counter keeps decrementing through wait mode.
- R9: Mode bits 0 and 1 are sticky. A write of 0 cannot clear them, and only reset clears them. The mode register reads back as {5'b0, 1'b0, bit1, bit0}.
- R10: The underflow output is a single-cycle pulse, registered on the tick that finds the counter at 0. The counter reloads full scale on that same edge and repeats the same period without further writes.
- R11: Synchronous reset clears the prescaler select, the unlock bit and the mode bits, drives all outputs low, and sets the counter to full scale without starting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick | input | 1 | System-clock count enable (normal source) |
| osc_tick | input | 1 | Free-running oscillator count enable (protected source) |
| wait_mode | input | 1 | CPU is in wait mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 start, 2 protect, 3 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| stop_req | output | 1 | One-cycle stop-mode request |
| wdt_irq | output | 1 | One-cycle underflow interrupt request |
| wdt_rst | output | 1 | One-cycle underflow reset request |

## Verification
The bench builds the block with CNT_W=6, PRE_LO_LOG2=2 and PRE_HI_LOG2=3. At these sizes a normal period is 256 or 512 system ticks and a protected period is 64 oscillator ticks. Whole underflow periods, the automatic reload and a second period therefore fit in a short run and can be measured to the exact cycle. The counter width still exceeds the five bits shown in the control register, so the read-only counter field and its freezing in wait mode remain observable.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_START = 2'd1,
        REG_PROT  = 2'd2,
        REG_MODE  = 2'd3
    } wdt_reg_e;

    localparam int BIT_SLOW   = 7;
    localparam int BIT_UNLOCK = 0;
    localparam int BIT_RSTSEL = 0;
    localparam int BIT_OSC    = 1;
    localparam int BIT_STOP   = 2;

    typedef struct packed {
        logic slow_div;
        logic unlock;
        logic rst_on_uf;
        logic osc_src;
    } wdt_cfg_t;

    function automatic logic [7:0] ctrl_view(input logic slow, input logic [4:0] hi);
        return {slow, 2'b00, hi};
    endfunction

    function automatic logic [7:0] mode_view(input wdt_cfg_t c);
        return {5'b0, 1'b0, c.osc_src, c.rst_on_uf};
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic [4:0] cnt_hi,
    output logic [7:0] bus_rdata,
    output wdt_cfg_t   cfg,
    output logic       start_pulse,
    output logic       stop_req
);
    wdt_reg_e sel;
    assign sel = wdt_reg_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            stop_req <= 1'b0;
        end else begin
            stop_req <= 1'b0;
            if (bus_wr) begin
                case (sel)
                    REG_CTRL: cfg.slow_div <= bus_wdata[BIT_SLOW];
                    REG_PROT: cfg.unlock   <= bus_wdata[BIT_UNLOCK];
                    REG_MODE: if (cfg.unlock) begin
                        cfg.rst_on_uf <= cfg.rst_on_uf | bus_wdata[BIT_RSTSEL];
                        cfg.osc_src   <= cfg.osc_src | bus_wdata[BIT_OSC];
                        stop_req      <= bus_wdata[BIT_STOP] & ~cfg.osc_src
                                         & ~bus_wdata[BIT_OSC];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign start_pulse = bus_wr && (sel == REG_START);

    always_comb begin
        case (sel)
            REG_CTRL: bus_rdata = ctrl_view(cfg.slow_div, cnt_hi);
            REG_PROT: bus_rdata = {7'b0, cfg.unlock};
            REG_MODE: bus_rdata = mode_view(cfg);
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int LO_LOG2 = 4,
    parameter int HI_LOG2 = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    input  logic slow,
    output logic tick
);
    localparam int PW = (HI_LOG2 > LO_LOG2) ? HI_LOG2 : LO_LOG2;
    localparam logic [PW-1:0] LIM_LO = PW'((1 << LO_LOG2) - 1);
    localparam logic [PW-1:0] LIM_HI = PW'((1 << HI_LOG2) - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;
    logic          wrap;

    assign lim  = slow ? LIM_HI : LIM_LO;
    assign wrap = (pre_q >= lim);
    assign tick = advance && wrap;

    always_ff @(posedge clk) begin
        if (rst || clear)
            pre_q <= '0;
        else if (advance)
            pre_q <= wrap ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic             to_reset,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             irq_q,
    output logic             rst_q
);
    localparam logic [CNT_W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= FULL;
            running <= 1'b0;
            irq_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
            if (start) begin
                count   <= FULL;
                running <= 1'b1;
            end else if (running && tick) begin
                if (count == '0) begin
                    count <= FULL;
                    irq_q <= ~to_reset;
                    rst_q <= to_reset;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int PRE_LO_LOG2 = 4,
    parameter int PRE_HI_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_tick,
    input  logic       osc_tick,
    input  logic       wait_mode,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       stop_req,
    output logic       wdt_irq,
    output logic       wdt_rst
);
    wdt_cfg_t         cfg_q;
    logic             start_pulse;
    logic [CNT_W-1:0] cnt_q;
    logic             running;
    logic             pre_adv;
    logic             pre_tick;
    logic             cnt_tick;

    wdt_regs regs_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cnt_hi      (cnt_q[CNT_W-1 -: 5]),
        .bus_rdata   (bus_rdata),
        .cfg         (cfg_q),
        .start_pulse (start_pulse),
        .stop_req    (stop_req)
    );

    assign pre_adv = running && sys_tick && !wait_mode && !cfg_q.osc_src;

    wdt_prescaler #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2)) pre_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_pulse),
        .advance (pre_adv),
        .slow    (cfg_q.slow_div),
        .tick    (pre_tick)
    );

    assign cnt_tick = cfg_q.osc_src ? osc_tick : pre_tick;

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start_pulse),
        .tick     (cnt_tick),
        .to_reset (cfg_q.rst_on_uf),
        .count    (cnt_q),
        .running  (running),
        .irq_q    (wdt_irq),
        .rst_q    (wdt_rst)
    );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             wait_mode,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             stop_req,
    input logic             wdt_irq,
    input logic             wdt_rst,
    input wdt_cfg_t         cfg_q,
    input logic [CNT_W-1:0] cnt_q
);
    logic start_wr, mode_wr;
    assign start_wr = bus_wr && (bus_addr == 2'd1);
    assign mode_wr  = bus_wr && (bus_addr == 2'd3);

    a_r1_start_reload: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (cnt_q == '1));
    a_r4_locked_mode: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !cfg_q.unlock) |=> ($stable(cfg_q.rst_on_uf) && $stable(cfg_q.osc_src)));
    a_r5_one_action: assert property (@(posedge clk) disable iff (rst)
        !(wdt_irq && wdt_rst));
    a_r7_stop_blocked: assert property (@(posedge clk) disable iff (rst)
        cfg_q.osc_src |-> !stop_req);
    a_r8_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (wait_mode && !cfg_q.osc_src && !start_wr) |=> $stable(cnt_q));
    a_r9_sticky_osc: assert property (@(posedge clk) disable iff (rst)
        cfg_q.osc_src |=> cfg_q.osc_src);
    a_r9_sticky_rstsel: assert property (@(posedge clk) disable iff (rst)
        cfg_q.rst_on_uf |=> cfg_q.rst_on_uf);
    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        wdt_irq |=> !wdt_irq);
    a_r10_rst_single: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);
    a_r10_uf_reload: assert property (@(posedge clk) disable iff (rst)
        (wdt_irq || wdt_rst) |-> (cnt_q == '1));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wait_mode (wait_mode),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .stop_req  (stop_req),
    .wdt_irq   (wdt_irq),
    .wdt_rst   (wdt_rst),
    .cfg_q     (cfg_q),
    .cnt_q     (cnt_q)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 6;
    localparam int LO = 2;
    localparam int HI = 3;
    localparam int P_LO  = (1 << CW) * (1 << LO);
    localparam int P_HI  = (1 << CW) * (1 << HI);
    localparam int P_OSC = (1 << CW);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_tick = 1'b1;
    logic       osc_tick = 1'b0;
    logic       wait_mode = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_req, wdt_irq, wdt_rst;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.CNT_W(CW), .PRE_LO_LOG2(LO), .PRE_HI_LOG2(HI)) dut_i (
        .clk(clk), .rst(rst), .sys_tick(sys_tick), .osc_tick(osc_tick),
        .wait_mode(wait_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_req(stop_req),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    // {write, addr, wdata, expected read of addr afterwards}
    localparam logic [18:0] VEC [0:6] = '{
        {1'b0, 2'd0, 8'h00, 8'h1F},  // R11 R3 reset view of control
        {1'b1, 2'd0, 8'hFF, 8'h9F},  // R3 reserved bits read 0
        {1'b1, 2'd0, 8'h00, 8'h1F},  // R3 select cleared
        {1'b1, 2'd3, 8'h03, 8'h00},  // R4 locked mode write ignored
        {1'b1, 2'd2, 8'h01, 8'h01},  // R4 unlock bit set
        {1'b1, 2'd2, 8'h00, 8'h00},  // R4 unlock bit cleared
        {1'b1, 2'd1, 8'hA5, 8'h00}   // R1 start register reads 0
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; bus_wr = 1'b0;
        sys_tick = 1'b1; osc_tick = 1'b0; wait_mode = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic measure(output int n, output bit s_irq, output bit s_rst);
        n = 0; s_irq = 0; s_rst = 0;
        while (n < 4000) begin
            @(negedge clk); n++;
            if (wdt_irq) s_irq = 1;
            if (wdt_rst) s_rst = 1;
            if (wdt_irq || wdt_rst) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rv, rv2;
        int n;
        bit si, sr;
        bit any;

        do_reset();
        check("R11 outputs after reset", {stop_req, wdt_irq, wdt_rst}, 0);

        for (int i = 0; i < 7; i++) begin
            if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
            else @(negedge clk);
            rd(VEC[i][17:16], rv);
            check($sformatf("R3/R4 vector %0d", i), rv, VEC[i][7:0]);
        end

        // R1 idle until started
        do_reset();
        any = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); if (wdt_irq || wdt_rst) any = 1;
        end
        rd(2'd0, rv);
        check("R1 idle no pulse", any, 0);
        check("R1 idle counter full", rv, 8'h1F);

        wr(2'd1, 8'h5A);
        measure(n, si, sr);
        check("R2 period div-low", n, P_LO);
        check("R5 irq chosen", {si, sr}, 2'b10);
        @(negedge clk);
        check("R10 pulse one cycle", wdt_irq, 0);
        measure(n, si, sr);
        check("R10 reload second period", n, P_LO - 1);

        wr(2'd0, 8'h80);
        wr(2'd1, 8'h00);
        measure(n, si, sr);
        check("R2 period div-high", n, P_HI);

        // R8 wait freezes normal mode
        do_reset();
        wr(2'd1, 8'h00);
        repeat (20) @(negedge clk);
        wait_mode = 1'b1;
        @(negedge clk); rd(2'd0, rv);
        any = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); if (wdt_irq) any = 1;
        end
        rd(2'd0, rv2);
        check("R8 frozen in wait", rv2, rv);
        check("R3 counter field moved", (rv[4:0] != 5'h1F), 1);
        check("R8 no pulse in wait", any, 0);
        wait_mode = 1'b0;

        // R7 stop request in normal mode
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h04);
        check("R7 stop pulse", stop_req, 1);
        @(negedge clk);
        check("R7 stop pulse width", stop_req, 0);

        // R5 reset action
        wr(2'd3, 8'h01);
        rd(2'd3, rv);
        check("R5 mode readback", rv, 8'h01);
        wr(2'd1, 8'h00);
        measure(n, si, sr);
        check("R5 rst chosen", {si, sr}, 2'b01);
        check("R5 period", n, P_LO);

        // R6 oscillator source, CPU ticks stalled, wait mode held
        wr(2'd3, 8'h06);
        check("R7 stop refused with osc", stop_req, 0);
        sys_tick = 1'b0; osc_tick = 1'b1; wait_mode = 1'b1;
        wr(2'd1, 8'h00);
        measure(n, si, sr);
        check("R6 R8 osc period in wait", n, P_OSC);
        wr(2'd3, 8'h04);
        check("R7 stop blocked", stop_req, 0);
        wr(2'd3, 8'h00);
        rd(2'd3, rv);
        check("R9 sticky bits", rv, 8'h03);
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h00);
        measure(n, si, sr);
        check("R6 prescaler bypassed", n, P_OSC);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule